// File: doc/BRIEF.md
# CRT Controller Register Bank with Light-Pen Latch

This block is the programmable register bank of a character-based CRT timing controller. The host reaches it over a byte-wide port bus through two ports. The even port is a pointer that selects one of the internal registers. The odd port reads and writes the register that the pointer selects. Address decoding is deliberately incomplete, so the pointer/data pair answers at several consecutive even/odd locations.

Each register keeps only the bits that the raster logic uses. The horizontal and vertical totals, displayed counts, adjust, sync positions, sync widths, character-row height, cursor shape, cursor location and display start address are driven out as decoded fields for the timing counters. One sync-width register has two build variants. In the extended variant the vertical sync width is programmable in its upper nibble. In the base variant that width is fixed at 16 lines.

A light-pen latch sits beside the registers. A write to the preset strobe port copies the current refresh address into the light-pen register once, and later presets are ignored. A write to the clear strobe port re-arms the latch. A registered pulse marks every change to a value that alters the raster geometry, so a downstream timing generator can restart its frame.

Top module: `crtc_regbank`

## Requirements
- R1: A write to an even port in the mirrored range (address 2m, m = 0..3) loads all 8 bits of the pointer. A read from such a port returns the pointer.
- R2: A write to an odd port in the mirrored range (address 2m+1) stores the write data, masked, into the register the pointer selects. A read from an odd port returns the stored masked value.
- R3: The four pointer/data pairs at addresses 0/1, 2/3, 4/5 and 6/7 behave identically. A read from any address outside 0..7 returns 8'hFF.
- R4: Register 3 holds the horizontal sync width in bits 3:0. In the extended variant, bits 7:4 are kept and drive the vertical sync width output. In the base variant, bits 7:4 read as zero and the vertical sync width output is 16.
- R5: Register 9 (character-row height) keeps only bits 4:0.
- R6: Register 10 keeps bits 5:0, and bits 4:0 give the cursor start line. The cursor enable output goes low exactly when the last write to register 10 had bits 6:5 equal to 2'b01.
- R7: Registers 0, 1, 2, 4, 5, 6, 7, 13, 14, 15 and 17 keep 8 bits. Registers 11 keeps 5 bits, and registers 12 and 16 keep 6 bits. The start address is {reg12[5:0], reg13}, the cursor location is {reg14, reg15} and the light-pen address is {reg16[5:0], reg17}.
- R8: Pointer values 8 and above 17 select nothing. A read through the data port returns 8'hFF, and a write through the data port changes no register.
- R9: A write to address 11 clears the light-pen hit flag.
- R10: A write to address 12 while the hit flag is clear loads the current address into the light-pen register and sets the flag. While the flag is set, such a write has no effect.
- R11: Decoded output fields show a data-port write from the clock edge that accepts it. Without a write they hold their value.
- R12: The change pulse is high for exactly the cycle after a data-port write to register 0, 1, 4, 5, 6 or 9 that alters the stored masked value. It is low in every other cycle.
- R13: After reset, all registers and the pointer are zero, the hit flag is clear and the cursor is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Port address within the block window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| cur_addr | input | RA_W | Current refresh address |
| rd_data | output | 8 | Read data for bus_addr (combinational) |
| h_total | output | 8 | Horizontal total |
| h_disp | output | 8 | Horizontal displayed characters |
| h_sync_pos | output | 8 | Horizontal sync position |
| h_sync_wid | output | 4 | Horizontal sync width |
| v_total | output | 8 | Vertical total in rows |
| v_adjust | output | 8 | Vertical adjust lines |
| v_rows | output | 8 | Displayed rows |
| v_sync_pos | output | 8 | Vertical sync position |
| v_sync_wid | output | 5 | Vertical sync width in lines |
| max_scan | output | 5 | Character-row height minus one |
| cur_start_line | output | 5 | Cursor first scan line |
| cur_end_line | output | 5 | Cursor last scan line |
| cur_enable | output | 1 | Cursor shown |
| cur_loc | output | 16 | Cursor location |
| start_addr | output | RA_W | Display start address |
| lpen_addr | output | RA_W | Light-pen register |
| lpen_hit | output | 1 | Light-pen hit flag |
| geom_chg | output | 1 | Geometry change pulse |

## Verification
The bench builds two copies side by side on one shared bus. Instance u0 uses EXTENDED=1 and a second instance uses EXTENDED=0, both with the default 4-bit window, four mirrors and a 14-bit refresh address. Driving both copies with the same writes lets every register-3 access compare the programmable vertical sync width against the fixed value of 16. With the 14-bit address, the preset capture and the 6-bit masks on registers 12 and 16 fall on a real bit boundary. Random writes spread over all four mirrors and over pointers beyond the implemented range reach the all-ones read path and the ignored-write path.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
   localparam int NREG = 16;
   localparam logic [7:0] IX_SYNCW  = 8'h03;
   localparam logic [7:0] IX_ROWH   = 8'h09;
   localparam logic [7:0] IX_CSHAPE = 8'h0A;
   localparam logic [7:0] IX_HOLE   = 8'h08;
   localparam logic [7:0] IX_LP_HI  = 8'h10;
   localparam logic [7:0] IX_LP_LO  = 8'h11;

   // bits kept by each register; ra_w sets the width of the high address halves
   function automatic logic [7:0] keep_mask(input int i, input bit ext, input int ra_w);
      logic [7:0] hi;
      hi = 8'((1 << (ra_w - 8)) - 1);
      case (i)
         3:       keep_mask = ext ? 8'hFF : 8'h0F;
         8:       keep_mask = 8'h00;
         9:       keep_mask = 8'h1F;
         10:      keep_mask = 8'h3F;
         11:      keep_mask = 8'h1F;
         12, 16:  keep_mask = hi;
         default: keep_mask = 8'hFF;
      endcase
   endfunction

   function automatic bit is_geom(input logic [7:0] i);
      is_geom = (i == 8'd0) || (i == 8'd1) || (i == 8'd4) ||
                (i == 8'd5) || (i == 8'd6) || (i == 8'd9);
   endfunction
endpackage

// File: rtl/crtc_port_decode.sv
module crtc_port_decode #(
   parameter int ADDR_W   = 4,
   parameter int MIRRORS  = 4,
   parameter int CLR_PORT = 11,
   parameter int SET_PORT = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic              idx_sel,
   output logic              dat_sel,
   output logic              idx_wr,
   output logic              dat_wr,
   output logic              clr_stb,
   output logic              set_stb
);
   localparam logic [ADDR_W-1:0] PAIR_END = ADDR_W'(2 * MIRRORS);
   localparam logic [ADDR_W-1:0] CLR_A    = ADDR_W'(CLR_PORT);
   localparam logic [ADDR_W-1:0] SET_A    = ADDR_W'(SET_PORT);

   initial begin : elab_chk
      if (2 * MIRRORS > (1 << ADDR_W) || CLR_PORT < 2 * MIRRORS ||
          SET_PORT < 2 * MIRRORS || CLR_PORT == SET_PORT ||
          CLR_PORT >= (1 << ADDR_W) || SET_PORT >= (1 << ADDR_W))
         $error("crtc_port_decode: port layout overlaps or exceeds window");
   end

   logic in_pairs;
   assign in_pairs = (addr < PAIR_END);
   assign idx_sel  = in_pairs && !addr[0];
   assign dat_sel  = in_pairs &&  addr[0];
   assign idx_wr   = wr && idx_sel;
   assign dat_wr   = wr && dat_sel;
   assign clr_stb  = wr && (addr == CLR_A);
   assign set_stb  = wr && (addr == SET_A);
endmodule

// File: rtl/crtc_lpen_latch.sv
module crtc_lpen_latch #(
   parameter int RA_W = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_stb,
   input  logic            set_stb,
   input  logic [RA_W-1:0] cur_addr,
   input  logic            hi_wr,
   input  logic            lo_wr,
   input  logic [7:0]      wdata,
   output logic [RA_W-1:0] lp_q,
   output logic            hit_q
);
   localparam int HI_W = RA_W - 8;

   initial begin : elab_chk
      if (RA_W < 9 || RA_W > 16) $error("crtc_lpen_latch: RA_W must be 9..16");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lp_q  <= '0;
         hit_q <= 1'b0;
      end else begin
         if (clr_stb) hit_q <= 1'b0;
         if (set_stb && !hit_q) begin
            lp_q  <= cur_addr;
            hit_q <= 1'b1;
         end
         if (hi_wr) lp_q[RA_W-1:8] <= wdata[HI_W-1:0];
         if (lo_wr) lp_q[7:0]      <= wdata;
      end
   end
endmodule

// File: rtl/crtc_reg_store.sv
module crtc_reg_store
   import crtc_pkg::*;
#(
   parameter bit EXTENDED = 1'b0,
   parameter int RA_W     = 14
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      idx_sel,
   input  logic                      dat_sel,
   input  logic                      idx_wr,
   input  logic                      dat_wr,
   input  logic [7:0]                wdata,
   input  logic [RA_W-1:0]           lpen_val,
   output logic [NREG-1:0][7:0]      regs_q,
   output logic [7:0]                idx_q,
   output logic                      cur_en_q,
   output logic                      chg_q,
   output logic [7:0]                rd_data
);
   localparam logic [7:0] NREG_B = 8'(NREG);

   logic       in_bank;
   logic [7:0] new_val;
   assign in_bank = (idx_q < NREG_B);
   assign new_val = wdata & keep_mask(int'(idx_q), EXTENDED, RA_W);

   always_ff @(posedge clk) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_wr) idx_q <= wdata;
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [7:0] KEEP = keep_mask(g, EXTENDED, RA_W);
      always_ff @(posedge clk) begin
         if (!rst_n)                           regs_q[g] <= '0;
         else if (dat_wr && idx_q == 8'(g))    regs_q[g] <= wdata & KEEP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_en_q <= 1'b1;
         chg_q    <= 1'b0;
      end else begin
         if (dat_wr && idx_q == IX_CSHAPE) cur_en_q <= (wdata[6:5] != 2'b01);
         chg_q <= dat_wr && in_bank && is_geom(idx_q) &&
                  (new_val != regs_q[idx_q[3:0]]);
      end
   end

   always_comb begin
      rd_data = 8'hFF;
      if (idx_sel) rd_data = idx_q;
      else if (dat_sel) begin
         if (in_bank && idx_q != IX_HOLE) rd_data = regs_q[idx_q[3:0]];
         else if (idx_q == IX_LP_HI)      rd_data = 8'(lpen_val >> 8);
         else if (idx_q == IX_LP_LO)      rd_data = lpen_val[7:0];
      end
   end
endmodule

// File: rtl/crtc_regbank.sv
module crtc_regbank
   import crtc_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int MIRRORS  = 4,
   parameter int CLR_PORT = 11,
   parameter int SET_PORT = 12,
   parameter bit EXTENDED = 1'b0,
   parameter int RA_W     = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_wr,
   input  logic [RA_W-1:0]   cur_addr,
   output logic [7:0]        rd_data,
   output logic [7:0]        h_total,
   output logic [7:0]        h_disp,
   output logic [7:0]        h_sync_pos,
   output logic [3:0]        h_sync_wid,
   output logic [7:0]        v_total,
   output logic [7:0]        v_adjust,
   output logic [7:0]        v_rows,
   output logic [7:0]        v_sync_pos,
   output logic [4:0]        v_sync_wid,
   output logic [4:0]        max_scan,
   output logic [4:0]        cur_start_line,
   output logic [4:0]        cur_end_line,
   output logic              cur_enable,
   output logic [15:0]       cur_loc,
   output logic [RA_W-1:0]   start_addr,
   output logic [RA_W-1:0]   lpen_addr,
   output logic              lpen_hit,
   output logic              geom_chg
);
   localparam int HI_W = RA_W - 8;

   logic idx_sel, dat_sel, idx_wr, dat_wr, clr_stb, set_stb;
   logic [NREG-1:0][7:0] regs;
   logic [7:0] sel_idx;

   crtc_port_decode #(
      .ADDR_W(ADDR_W), .MIRRORS(MIRRORS), .CLR_PORT(CLR_PORT), .SET_PORT(SET_PORT)
   ) u_dec (
      .addr(bus_addr), .wr(bus_wr), .idx_sel(idx_sel), .dat_sel(dat_sel),
      .idx_wr(idx_wr), .dat_wr(dat_wr), .clr_stb(clr_stb), .set_stb(set_stb)
   );

   crtc_reg_store #(.EXTENDED(EXTENDED), .RA_W(RA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .idx_sel(idx_sel), .dat_sel(dat_sel),
      .idx_wr(idx_wr), .dat_wr(dat_wr), .wdata(bus_wdata), .lpen_val(lpen_addr),
      .regs_q(regs), .idx_q(sel_idx), .cur_en_q(cur_enable), .chg_q(geom_chg),
      .rd_data(rd_data)
   );

   crtc_lpen_latch #(.RA_W(RA_W)) u_lpen (
      .clk(clk), .rst_n(rst_n), .clr_stb(clr_stb), .set_stb(set_stb),
      .cur_addr(cur_addr),
      .hi_wr(dat_wr && sel_idx == IX_LP_HI),
      .lo_wr(dat_wr && sel_idx == IX_LP_LO),
      .wdata(bus_wdata), .lp_q(lpen_addr), .hit_q(lpen_hit)
   );

   assign h_total        = regs[0];
   assign h_disp         = regs[1];
   assign h_sync_pos     = regs[2];
   assign h_sync_wid     = regs[3][3:0];
   assign v_total        = regs[4];
   assign v_adjust       = regs[5];
   assign v_rows         = regs[6];
   assign v_sync_pos     = regs[7];
   assign max_scan       = regs[9][4:0];
   assign cur_start_line = regs[10][4:0];
   assign cur_end_line   = regs[11][4:0];
   assign start_addr     = {regs[12][HI_W-1:0], regs[13]};
   assign cur_loc        = {regs[14], regs[15]};

   if (EXTENDED) begin : g_vsw_prog
      assign v_sync_wid = {1'b0, regs[3][7:4]};
   end else begin : g_vsw_fixed
      assign v_sync_wid = 5'd16;
   end
endmodule

// File: rtl/crtc_regbank_chk.sv
module crtc_regbank_chk #(
   parameter int ADDR_W   = 4,
   parameter int MIRRORS  = 4,
   parameter int CLR_PORT = 11,
   parameter int SET_PORT = 12,
   parameter int RA_W     = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic              bus_wr,
   input logic [RA_W-1:0]   cur_addr,
   input logic [7:0]        sel_idx,
   input logic [RA_W-1:0]   lpen_addr,
   input logic              lpen_hit,
   input logic              cur_enable,
   input logic [4:0]        max_scan,
   input logic              geom_chg
);
   localparam logic [ADDR_W-1:0] PAIR_END = ADDR_W'(2 * MIRRORS);
   logic pw_idx, pw_dat, pw_clr, pw_set;
   assign pw_idx = bus_wr && bus_addr < PAIR_END && !bus_addr[0];
   assign pw_dat = bus_wr && bus_addr < PAIR_END &&  bus_addr[0];
   assign pw_clr = bus_wr && bus_addr == ADDR_W'(CLR_PORT);
   assign pw_set = bus_wr && bus_addr == ADDR_W'(SET_PORT);

   AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      pw_idx |=> sel_idx == $past(bus_wdata)); // R1
   AST_CLR_DROPS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      pw_clr |=> !lpen_hit); // R9
   AST_SET_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
      pw_set && !lpen_hit |=> lpen_hit && lpen_addr == $past(cur_addr)); // R10
   AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      pw_set && lpen_hit |=> lpen_hit && $stable(lpen_addr)); // R10
   AST_CURSOR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      pw_dat && sel_idx == 8'h0A && bus_wdata[6:5] == 2'b01 |=> !cur_enable); // R6
   AST_ROWH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pw_dat |=> $stable(max_scan)); // R11
   AST_CHG_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !pw_dat |=> !geom_chg); // R12
endmodule

bind crtc_regbank crtc_regbank_chk #(
   .ADDR_W(ADDR_W), .MIRRORS(MIRRORS), .CLR_PORT(CLR_PORT),
   .SET_PORT(SET_PORT), .RA_W(RA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_wr(bus_wr), .cur_addr(cur_addr), .sel_idx(sel_idx),
   .lpen_addr(lpen_addr), .lpen_hit(lpen_hit), .cur_enable(cur_enable),
   .max_scan(max_scan), .geom_chg(geom_chg)
);

// File: tb/sim_crtc_regbank.sv
`timescale 1ns/1ps
module sim_crtc_regbank;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic [13:0] cur_addr = '0;

   logic [7:0] rd [2];
   logic [7:0] ht [2], hd [2], hsp [2], vt [2], va [2], vr [2], vsp [2];
   logic [3:0] hsw [2];
   logic [4:0] vsw [2], ms [2], csl [2], cel [2];
   logic       cen [2], hit [2], chg [2];
   logic [15:0] cl [2];
   logic [13:0] sa [2], lpa [2];

   always #2 clk = ~clk;

   for (genvar u = 0; u < 2; u++) begin : g_dut
      if (u == 0) begin : g_ext
         crtc_regbank #(.EXTENDED(1'b1)) u0 (
            .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
            .bus_wr(bus_wr), .cur_addr(cur_addr), .rd_data(rd[u]),
            .h_total(ht[u]), .h_disp(hd[u]), .h_sync_pos(hsp[u]), .h_sync_wid(hsw[u]),
            .v_total(vt[u]), .v_adjust(va[u]), .v_rows(vr[u]), .v_sync_pos(vsp[u]),
            .v_sync_wid(vsw[u]), .max_scan(ms[u]), .cur_start_line(csl[u]),
            .cur_end_line(cel[u]), .cur_enable(cen[u]), .cur_loc(cl[u]),
            .start_addr(sa[u]), .lpen_addr(lpa[u]), .lpen_hit(hit[u]), .geom_chg(chg[u]));
      end else begin : g_base
         crtc_regbank #(.EXTENDED(1'b0)) u1 (
            .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
            .bus_wr(bus_wr), .cur_addr(cur_addr), .rd_data(rd[u]),
            .h_total(ht[u]), .h_disp(hd[u]), .h_sync_pos(hsp[u]), .h_sync_wid(hsw[u]),
            .v_total(vt[u]), .v_adjust(va[u]), .v_rows(vr[u]), .v_sync_pos(vsp[u]),
            .v_sync_wid(vsw[u]), .max_scan(ms[u]), .cur_start_line(csl[u]),
            .cur_end_line(cel[u]), .cur_enable(cen[u]), .cur_loc(cl[u]),
            .start_addr(sa[u]), .lpen_addr(lpa[u]), .lpen_hit(hit[u]), .geom_chg(chg[u]));
      end
   end

   int nchk = 0, nfail = 0;
   logic [7:0] mreg [2][18];
   logic [7:0] m_idx;
   logic       m_hit, m_en, m_chg;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] bmask(input int i, input bit ext);
      case (i)
         3:      return ext ? 8'hFF : 8'h0F;
         9, 11:  return 8'h1F;
         10, 12, 16: return 8'h3F;
         default: return (i <= 17 && i != 8) ? 8'hFF : 8'h00;
      endcase
   endfunction

   function automatic bit impl(input int i);
      return i <= 17 && i != 8;
   endfunction

   function automatic bit geom(input int i);
      return i == 0 || i == 1 || i == 4 || i == 5 || i == 6 || i == 9;
   endfunction

   function automatic logic [7:0] exp_rd(input int u, input int i);
      return impl(i) ? mreg[u][i] : 8'hFF;
   endfunction

   task automatic bwr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic do_idx(input int m, input logic [7:0] v);
      bwr(4'(2 * m), v);
      m_idx = v; m_chg = 1'b0;
   endtask

   task automatic do_dat(input int m, input logic [7:0] v);
      int i;
      i = int'(m_idx);
      m_chg = 1'b0;
      if (impl(i)) begin
         for (int u = 0; u < 2; u++) begin
            logic [7:0] nv;
            nv = v & bmask(i, u == 0);
            if (geom(i) && nv != mreg[u][i]) m_chg = 1'b1;
            mreg[u][i] = nv;
         end
      end
      if (i == 10) m_en = (v[6:5] != 2'b01);
      bwr(4'(2 * m + 1), v);
   endtask

   task automatic do_clr();
      bwr(4'd11, $urandom);
      m_hit = 1'b0; m_chg = 1'b0;
   endtask

   task automatic do_set(input logic [13:0] a);
      cur_addr = a;
      if (!m_hit) begin
         for (int u = 0; u < 2; u++) begin
            mreg[u][16] = {2'b00, a[13:8]};
            mreg[u][17] = a[7:0];
         end
         m_hit = 1'b1;
      end
      bwr(4'd12, $urandom);
      m_chg = 1'b0;
   endtask

   // sample right after an accepting edge: fields and pulse (R11, R12)
   task automatic check_fields(input string tag);
      for (int u = 0; u < 2; u++) begin
         check({tag, " R12 geom_chg"}, 32'(chg[u]), 32'(m_chg));
         check({tag, " R11 h_total"}, 32'(ht[u]), 32'(mreg[u][0]));
         check({tag, " R11 fields"},
               {hd[u], hsp[u], vt[u], va[u]},
               {mreg[u][1], mreg[u][2], mreg[u][4], mreg[u][5]});
         check({tag, " R11 fields2"}, {vr[u], vsp[u], 3'b0, ms[u], 4'b0, hsw[u]},
               {mreg[u][6], mreg[u][7], mreg[u][9], 4'b0, mreg[u][3][3:0]});
         check({tag, " R4 v_sync_wid"}, 32'(vsw[u]),
               u == 0 ? 32'(mreg[0][3][7:4]) : 32'd16);
         check({tag, " R6 cursor"}, {27'b0, cen[u], csl[u]}, {27'b0, m_en, mreg[u][10][4:0]});
         check({tag, " R7 addrs"}, {cl[u], 2'b0, sa[u]},
               {mreg[u][14], mreg[u][15], 2'b0, mreg[u][12][5:0], mreg[u][13]});
         check({tag, " R7 end/lpen"}, {11'b0, cel[u], 2'b0, lpa[u]},
               {11'b0, mreg[u][11][4:0], 2'b0, mreg[u][16][5:0], mreg[u][17]});
         check({tag, " R10 hit"}, 32'(hit[u]), 32'(m_hit));
      end
   endtask

   task automatic read_data(input int m, input string tag);
      bus_addr = 4'(2 * m + 1);
      #0.2;
      for (int u = 0; u < 2; u++)
         check({tag, " R2 data read"}, 32'(rd[u]), 32'(exp_rd(u, int'(m_idx))));
   endtask

   task automatic scan_all();
      for (int i = 0; i < 20; i++) begin
         do_idx(i % 4, 8'(i));
         read_data((i + 1) % 4, "scan R8");
      end
   endtask

   bit done = 1'b0;
   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++; nchk++;
         $display("FAIL watchdog R13 actual=hung expected=finished");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd4242));
      for (int u = 0; u < 2; u++) for (int i = 0; i < 18; i++) mreg[u][i] = 8'h00;
      m_idx = 8'h00; m_hit = 1'b0; m_en = 1'b1; m_chg = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      check_fields("R13 reset");
      bus_addr = 4'd0; #0.2;
      check("R13 index", 32'(rd[0]), 32'h0);
      read_data(0, "R13 reg0");

      // R1 index readback on every mirror, R3
      for (int m = 0; m < 4; m++) begin
         do_idx(m, 8'hC0 + 8'(m));
         bus_addr = 4'(2 * ((m + 1) % 4)); #0.2;
         check("R1 R3 index mirror", 32'(rd[1]), 32'(m_idx));
      end
      for (int a = 8; a < 16; a++) begin
         bus_addr = 4'(a); #0.2;
         check("R3 outside window", 32'(rd[0]), 32'hFF);
      end

      // R4 variant field
      do_idx(0, 8'd3); do_dat(1, 8'hA5); check_fields("R4");
      read_data(2, "R4");
      // R5 row height mask and R12 pulse
      do_idx(1, 8'd9); do_dat(3, 8'hFF); check_fields("R5 R12 first");
      check("R12 pulse", 32'(chg[0]), 32'd1);
      read_data(0, "R5");
      do_dat(2, 8'h3F); check_fields("R12 same value");
      check("R12 no pulse", 32'(chg[0]), 32'd0);
      @(negedge clk); #1 check("R12 one cycle", 32'(chg[1]), 32'd0);
      // R6 cursor disable encoding
      do_idx(2, 8'h0A);
      do_dat(0, 8'h20); check_fields("R6 01"); read_data(1, "R6");
      do_dat(0, 8'h60); check_fields("R6 11");
      do_dat(0, 8'h3F); check_fields("R6 01b");
      do_dat(0, 8'h5F); check_fields("R6 10"); read_data(3, "R6");
      // R8 ignored writes
      do_idx(0, 8'h08); do_dat(1, 8'h55); check_fields("R8 hole");
      read_data(1, "R8 hole");
      do_idx(0, 8'h12); do_dat(1, 8'hAA); check_fields("R8 high");
      do_idx(0, 8'hFF); do_dat(1, 8'h11); check_fields("R8 top");
      scan_all();
      // R9 R10 light pen
      do_clr(); check_fields("R9");
      do_set(14'h3ABC); check_fields("R10 capture");
      do_set(14'h0123); check_fields("R10 held");
      do_clr(); check_fields("R9 clear");
      do_set(14'h1234); check_fields("R10 recapture");
      do_idx(3, 8'h10); read_data(0, "R10 hi");
      do_idx(3, 8'h11); read_data(2, "R10 lo");
      do_dat(1, 8'h77); check_fields("R7 lpen lo write");

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if (op < 3) begin
            int r;
            r = int'($urandom_range(0, 9));
            do_idx(int'($urandom_range(0, 3)),
                   r == 0 ? 8'($urandom) : 8'($urandom_range(0, 18)));
         end else if (op < 7) do_dat(int'($urandom_range(0, 3)), 8'($urandom));
         else if (op == 7) do_clr();
         else if (op == 8) do_set(14'($urandom));
         else begin
            do_idx(int'($urandom_range(0, 3)), geom(int'(m_idx)) ? m_idx : 8'd0);
            do_dat(int'($urandom_range(0, 3)), mreg[0][int'(m_idx)]);
         end
         check_fields("random");
         read_data(int'($urandom_range(0, 3)), "random");
      end
      scan_all();

      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule